// File: doc/BRIEF.md
# USB Device Endpoint Prime/Flush Controller

This block keeps the per-endpoint prime and flush requests of a USB device controller. There are four endpoints, each with a transmit (IN) and a receive (OUT) direction. Software posts a request by writing ones to a 32-bit register. The block then asks a descriptor-fetch engine to prepare a buffer for each pending prime, one slot at a time. It discards the prepared buffer of any slot that software flushes, and it clears each request bit by itself once the work on it is finished. The fetch engine's automatic re-priming can also raise a prime bit from hardware.

A slot is one endpoint in one direction. Each slot holds three bits: a pending prime, a pending flush and a "buffer primed" flag. Software sees the eight primed flags on a separate status output. A fetch-control state machine issues the requests to the fetch engine. Its states are IDLE, ISSUE and WAIT. The transition IDLE→ISSUE is taken when the arbiter grants a slot, and the granted slot is latched on that edge. ISSUE→WAIT is taken unconditionally after the single request cycle. WAIT→WAIT holds until a done pulse arrives that names the latched slot. WAIT→IDLE is taken on that matching done.

Top module: `ep_prime_flush_ctrl`

## Requirements
- R1: Register offset 0 holds the prime requests and offset 1 holds the flush requests. In both registers, bit 16+n is transmit endpoint n and bit n is receive endpoint n. A read returns the pending bits combinationally from `reg_addr`.
- R2: Bits 31:20 and 15:4 of both registers always read zero, and writing them has no effect. Offsets 2 and 3 read zero and ignore writes.
- R3: Writing 1 to a request bit sets it on the next clock edge. Writing 0 leaves the bit unchanged.
- R4: For a granted slot, `fetch_req` is high for exactly one cycle, carrying `fetch_ep` and `fetch_dir` (1 = transmit). Only one request is outstanding at a time. On a `fetch_done` whose `fetch_done_ep`/`fetch_done_dir` match the outstanding request, the prime bit clears and the primed flag sets on the same edge. A done naming any other slot is ignored.
- R5: Pending primes are served in this order: endpoint 0 transmit, endpoint 0 receive, endpoint 1 transmit, and so on. The lowest endpoint goes first, and transmit goes before receive.
- R6: A `reprime_start` pulse sets the prime bit of the slot named by `reprime_ep`/`reprime_dir`. That bit clears when the matching fetch completes. When a set and a clear of a prime bit meet on one edge, the set wins.
- R7: A pending flush on a slot with no packet in progress clears the slot's primed flag and its flush bit on the next edge.
- R8: While `pkt_busy` is high for a slot, that slot's flush bit and primed flag stay unchanged.
- R9: A slot with a pending flush is not offered to the fetch engine. Its prime is served only after the flush has finished.
- R10: A `buf_consumed` pulse clears the slot's primed flag. A matching done on the same edge leaves the flag set.
- R11: After reset, all request bits and primed flags are zero and `fetch_req` is low.

Vectors `pkt_busy`, `buf_consumed` and `primed_status` use bits 3:0 for receive endpoints 0..3 and bits 7:4 for transmit endpoints 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 32 | Write data; ones set request bits |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| reprime_start | input | 1 | Hardware re-prime request pulse |
| reprime_ep | input | 2 | Endpoint of the re-prime |
| reprime_dir | input | 1 | Direction of the re-prime (1 = transmit) |
| pkt_busy | input | 8 | Packet in progress, per slot |
| buf_consumed | input | 8 | Buffer consumed pulse, per slot |
| primed_status | output | 8 | Primed flag per slot |
| fetch_req | output | 1 | One-cycle request to the fetch engine |
| fetch_ep | output | 2 | Endpoint of the request |
| fetch_dir | output | 1 | Direction of the request (1 = transmit) |
| fetch_done | input | 1 | One-cycle completion from the fetch engine |
| fetch_done_ep | input | 2 | Endpoint of the completion |
| fetch_done_dir | input | 1 | Direction of the completion |

## Verification
Some properties are checked by the assertions on every cycle:
- `fetch_req` never lasts longer than one cycle and never overlaps an outstanding request.
- Reserved read bits stay zero.
- A primed flag rises only right after a done.
- A busy slot keeps its flush pending.
- No request goes out for a slot whose flush was pending.

Other behaviour needs the bench's scenarios:
- The exact service order across all eight slots.
- Rejection of a done that names the wrong slot.
- Whether a written 0 changes nothing.
- Whether a deferred flush later lets the queued prime through.
- How re-prime and consume pulses change the readable state.

// File: rtl/epf_pkg.sv
package epf_pkg;

    // Fetch-control states
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/epf_slot.sv
// Request and status bits of one endpoint/direction slot.
module epf_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic prime_set,
    input  logic flush_set,
    input  logic busy,
    input  logic consume,
    input  logic ack,
    output logic prime_q,
    output logic flush_q,
    output logic primed_q,
    output logic cand
);

    logic flush_fin;

    // A flush finishes only while no packet is in flight
    assign flush_fin = flush_q & ~busy;
    // Flush goes first: a slot with a pending flush is not offered
    assign cand      = prime_q & ~flush_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prime_q  <= 1'b0;
            flush_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prime_q  <= prime_set | (prime_q & ~ack);
            flush_q  <= flush_set | (flush_q & ~flush_fin);
            primed_q <= ack | (primed_q & ~flush_fin & ~consume);
        end
    end

endmodule

// File: rtl/epf_arbiter.sv
// Fixed priority: lowest endpoint first, transmit before receive.
module epf_arbiter #(
    parameter int NUM_EP = 4,
    localparam int SLOTS = 2 * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic [SLOTS-1:0] cand,
    output logic             grant_valid,
    output logic [EP_W-1:0]  grant_ep,
    output logic             grant_dir
);

    always_comb begin
        grant_valid = 1'b0;
        grant_ep    = '0;
        grant_dir   = 1'b0;
        // Walk from lowest to highest priority; the last hit wins
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (cand[((k % 2) == 0) ? (NUM_EP + k / 2) : (k / 2)]) begin
                grant_valid = 1'b1;
                grant_ep    = EP_W'(k / 2);
                grant_dir   = ((k % 2) == 0);
            end
        end
    end

endmodule

// File: rtl/epf_fetch_fsm.sv
// Issues one fetch request at a time and waits for its matching done.
module epf_fetch_fsm
    import epf_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int SLOTS = 2 * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_valid,
    input  logic [EP_W-1:0]  grant_ep,
    input  logic             grant_dir,
    input  logic             fetch_done,
    input  logic [EP_W-1:0]  fetch_done_ep,
    input  logic             fetch_done_dir,
    output logic             fetch_req,
    output logic [EP_W-1:0]  fetch_ep,
    output logic             fetch_dir,
    output logic [SLOTS-1:0] ack_vec
);

    fetch_state_e state_q, state_d;
    logic [EP_W-1:0] sel_ep_q;
    logic            sel_dir_q;
    logic            done_match;

    assign done_match = fetch_done && (fetch_done_ep == sel_ep_q)
                        && (fetch_done_dir == sel_dir_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Latch the granted slot on leaving IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ep_q  <= '0;
            sel_dir_q <= 1'b0;
        end else if (state_q == FS_IDLE && grant_valid) begin
            sel_ep_q  <= grant_ep;
            sel_dir_q <= grant_dir;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (grant_valid) state_d = FS_ISSUE;
            FS_ISSUE: state_d = FS_WAIT;
            FS_WAIT:  if (done_match) state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_req = 1'b0;
        ack_vec   = '0;
        fetch_ep  = sel_ep_q;
        fetch_dir = sel_dir_q;
        unique case (state_q)
            FS_IDLE:  ;
            FS_ISSUE: fetch_req = 1'b1;
            FS_WAIT: begin
                if (done_match) begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (s == (sel_dir_q ? NUM_EP + int'(sel_ep_q) : int'(sel_ep_q)))
                            ack_vec[s] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ep_prime_flush_ctrl.sv
module ep_prime_flush_ctrl #(
    parameter int NUM_EP     = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int TX_LSB     = 16,
    parameter int RX_LSB     = 0,
    parameter int PRIME_ADDR = 0,
    parameter int FLUSH_ADDR = 1,
    localparam int SLOTS = 2 * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              reprime_start,
    input  logic [EP_W-1:0]   reprime_ep,
    input  logic              reprime_dir,
    input  logic [SLOTS-1:0]  pkt_busy,
    input  logic [SLOTS-1:0]  buf_consumed,
    output logic [SLOTS-1:0]  primed_status,
    output logic              fetch_req,
    output logic [EP_W-1:0]   fetch_ep,
    output logic              fetch_dir,
    input  logic              fetch_done,
    input  logic [EP_W-1:0]   fetch_done_ep,
    input  logic              fetch_done_dir
);

    logic [SLOTS-1:0] wr_bits;
    logic [SLOTS-1:0] prime_set, flush_set, reprime_vec;
    logic [SLOTS-1:0] prime_q, flush_q, primed_q, cand, ack_vec;
    logic             prime_wr, flush_wr;
    logic             grant_valid, grant_dir;
    logic [EP_W-1:0]  grant_ep;
    logic             unused_wdata;

    // Fold register fields into slot order: receive low, transmit high
    assign wr_bits      = {reg_wdata[TX_LSB +: NUM_EP], reg_wdata[RX_LSB +: NUM_EP]};
    assign unused_wdata = ^reg_wdata;
    assign prime_wr     = reg_wr && (reg_addr == ADDR_W'(PRIME_ADDR));
    assign flush_wr     = reg_wr && (reg_addr == ADDR_W'(FLUSH_ADDR));

    always_comb begin
        reprime_vec = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (reprime_start &&
                s == (reprime_dir ? NUM_EP + int'(reprime_ep) : int'(reprime_ep)))
                reprime_vec[s] = 1'b1;
        end
    end

    assign prime_set = (prime_wr ? wr_bits : '0) | reprime_vec;
    assign flush_set = flush_wr ? wr_bits : '0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        epf_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .prime_set (prime_set[g]),
            .flush_set (flush_set[g]),
            .busy      (pkt_busy[g]),
            .consume   (buf_consumed[g]),
            .ack       (ack_vec[g]),
            .prime_q   (prime_q[g]),
            .flush_q   (flush_q[g]),
            .primed_q  (primed_q[g]),
            .cand      (cand[g])
        );
    end

    epf_arbiter #(.NUM_EP(NUM_EP)) u_arb (
        .cand        (cand),
        .grant_valid (grant_valid),
        .grant_ep    (grant_ep),
        .grant_dir   (grant_dir)
    );

    epf_fetch_fsm #(.NUM_EP(NUM_EP)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .grant_valid    (grant_valid),
        .grant_ep       (grant_ep),
        .grant_dir      (grant_dir),
        .fetch_done     (fetch_done),
        .fetch_done_ep  (fetch_done_ep),
        .fetch_done_dir (fetch_done_dir),
        .fetch_req      (fetch_req),
        .fetch_ep       (fetch_ep),
        .fetch_dir      (fetch_dir),
        .ack_vec        (ack_vec)
    );

    // Read path
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(PRIME_ADDR)) begin
            reg_rdata[TX_LSB +: NUM_EP] = prime_q[SLOTS-1:NUM_EP];
            reg_rdata[RX_LSB +: NUM_EP] = prime_q[NUM_EP-1:0];
        end else if (reg_addr == ADDR_W'(FLUSH_ADDR)) begin
            reg_rdata[TX_LSB +: NUM_EP] = flush_q[SLOTS-1:NUM_EP];
            reg_rdata[RX_LSB +: NUM_EP] = flush_q[NUM_EP-1:0];
        end
    end

    assign primed_status = primed_q;

endmodule

// File: rtl/epf_checker.sv
module epf_checker #(
    parameter int NUM_EP = 4,
    parameter int DATA_W = 32,
    parameter int TX_LSB = 16,
    parameter int RX_LSB = 0,
    localparam int SLOTS = 2 * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [EP_W-1:0]   fetch_ep,
    input logic              fetch_dir,
    input logic              fetch_done,
    input logic [EP_W-1:0]   fetch_done_ep,
    input logic              fetch_done_dir,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [SLOTS-1:0]  primed_status,
    input logic [SLOTS-1:0]  pkt_busy,
    input logic [SLOTS-1:0]  flush_q
);

    localparam logic [DATA_W-1:0] FIELD = {{(DATA_W-NUM_EP){1'b0}}, {NUM_EP{1'b1}}};
    localparam logic [DATA_W-1:0] USED  = (FIELD << TX_LSB) | (FIELD << RX_LSB);

    logic             outst;
    logic [EP_W-1:0]  o_ep;
    logic             o_dir;
    logic [SLOTS-1:0] flush_d, busy_d, primed_d;
    logic             done_d;
    int               req_slot;

    always_comb req_slot = fetch_dir ? NUM_EP + int'(fetch_ep) : int'(fetch_ep);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst    <= 1'b0;
            o_ep     <= '0;
            o_dir    <= 1'b0;
            flush_d  <= '0;
            busy_d   <= '0;
            primed_d <= '0;
            done_d   <= 1'b0;
        end else begin
            if (fetch_req) begin
                outst <= 1'b1;
                o_ep  <= fetch_ep;
                o_dir <= fetch_dir;
            end else if (fetch_done && fetch_done_ep == o_ep && fetch_done_dir == o_dir) begin
                outst <= 1'b0;
            end
            flush_d  <= flush_q;
            busy_d   <= pkt_busy;
            primed_d <= primed_status;
            done_d   <= fetch_done;
        end
    end

    // R4
    fetch_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R4
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !outst);

    // R4
    primed_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((primed_status & ~primed_d) != '0) |-> done_d);

    // R2
    rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED) == '0);

    // R8
    flush_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_d & busy_d & ~flush_q) == '0);

    // R9
    no_fetch_under_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !flush_d[req_slot]);

endmodule

bind ep_prime_flush_ctrl epf_checker #(
    .NUM_EP (NUM_EP),
    .DATA_W (DATA_W),
    .TX_LSB (TX_LSB),
    .RX_LSB (RX_LSB)
) u_epf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_req      (fetch_req),
    .fetch_ep       (fetch_ep),
    .fetch_dir      (fetch_dir),
    .fetch_done     (fetch_done),
    .fetch_done_ep  (fetch_done_ep),
    .fetch_done_dir (fetch_done_dir),
    .reg_rdata      (reg_rdata),
    .primed_status  (primed_status),
    .pkt_busy       (pkt_busy),
    .flush_q        (flush_q)
);

// File: tb/ep_prime_flush_ctrl_bench.sv
module ep_prime_flush_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NEP = 4;
    localparam int NS  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reprime_start = 1'b0;
    logic [1:0]  reprime_ep = '0;
    logic        reprime_dir = 1'b0;
    logic [7:0]  pkt_busy = '0;
    logic [7:0]  buf_consumed = '0;
    logic [7:0]  primed_status;
    logic        fetch_req;
    logic [1:0]  fetch_ep;
    logic        fetch_dir;
    logic        fetch_done = 1'b0;
    logic [1:0]  fetch_done_ep = '0;
    logic        fetch_done_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_prime_flush_ctrl u_ep_prime_flush_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reprime_start(reprime_start), .reprime_ep(reprime_ep), .reprime_dir(reprime_dir),
        .pkt_busy(pkt_busy), .buf_consumed(buf_consumed), .primed_status(primed_status),
        .fetch_req(fetch_req), .fetch_ep(fetch_ep), .fetch_dir(fetch_dir),
        .fetch_done(fetch_done), .fetch_done_ep(fetch_done_ep), .fetch_done_dir(fetch_done_dir)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_prime[NS], m_flush[NS], m_primed[NS];
    int m_st, m_sel;

    function automatic int slot_of(int ep, bit tx);
        return tx ? NEP + ep : ep;
    endfunction

    function automatic int bitpos(int s);
        return (s < NEP) ? s : 16 + s - NEP;
    endfunction

    function automatic logic [31:0] m_word(logic [1:0] a);
        logic [31:0] w = '0;
        for (int s = 0; s < NS; s++) begin
            if (a == 2'd0 && m_prime[s]) w[bitpos(s)] = 1'b1;
            if (a == 2'd1 && m_flush[s]) w[bitpos(s)] = 1'b1;
        end
        return w;
    endfunction

    function automatic logic [31:0] m_stat();
        logic [31:0] w = '0;
        for (int s = 0; s < NS; s++) w[s] = m_primed[s];
        return w;
    endfunction

    always @(posedge clk) begin : mdl
        int hit;
        bit fin[NS];
        bit found;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                m_prime[s] = 0; m_flush[s] = 0; m_primed[s] = 0;
            end
            m_st = 0; m_sel = 0;
        end else begin
            hit = -1;
            if (m_st == 2 && fetch_done &&
                slot_of(int'(fetch_done_ep), fetch_done_dir) == m_sel) hit = m_sel;
            for (int s = 0; s < NS; s++) fin[s] = m_flush[s] && !pkt_busy[s];
            case (m_st)
                0: begin
                    found = 0;
                    for (int k = 0; k < NS; k++) begin
                        if (!found && m_prime[slot_of(k/2, (k%2)==0)] &&
                            !m_flush[slot_of(k/2, (k%2)==0)]) begin
                            found = 1; m_sel = slot_of(k/2, (k%2)==0);
                        end
                    end
                    if (found) m_st = 1;
                end
                1: m_st = 2;
                default: if (hit >= 0) m_st = 0;
            endcase
            for (int s = 0; s < NS; s++) begin
                if (s == hit) m_prime[s] = 0;
                if (reg_wr && reg_addr == 2'd0 && reg_wdata[bitpos(s)]) m_prime[s] = 1;
                if (reprime_start && slot_of(int'(reprime_ep), reprime_dir) == s) m_prime[s] = 1;
                if (fin[s]) m_flush[s] = 0;
                if (reg_wr && reg_addr == 2'd1 && reg_wdata[bitpos(s)]) m_flush[s] = 1;
                if (fin[s] || buf_consumed[s]) m_primed[s] = 0;
                if (s == hit) m_primed[s] = 1;
            end
        end
    end

    // Per-cycle comparison, away from the edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R4 R7 R10 primed_status", {24'b0, primed_status}, m_stat());
            chk("R4 fetch_req", {31'b0, fetch_req}, {31'b0, m_st == 1});
            if (m_st == 1)
                chk("R5 fetch target", {29'b0, fetch_dir, fetch_ep},
                    {29'b0, m_sel >= NEP, 2'(m_sel % NEP)});
            chk("R1 R2 reg_rdata", reg_rdata, m_word(reg_addr));
        end
    end

    // ---------------- fetch engine model ----------------
    bit eng_auto = 1;
    int eng_lat  = 1;
    int eng_wait = 0;
    logic [1:0] eng_ep;
    logic eng_dir;
    int inj_seq = 0, inj_seen = 0;
    logic [1:0] inj_ep;
    logic inj_dir;
    int log_q[$];

    always @(negedge clk) begin
        fetch_done = 1'b0;
        if (eng_auto && eng_wait > 0) begin
            eng_wait--;
            if (eng_wait == 0) begin
                fetch_done = 1'b1; fetch_done_ep = eng_ep; fetch_done_dir = eng_dir;
            end
        end
        if (inj_seq != inj_seen) begin
            inj_seen = inj_seq;
            fetch_done = 1'b1; fetch_done_ep = inj_ep; fetch_done_dir = inj_dir;
        end
        if (rst_n && fetch_req) begin
            log_q.push_back(slot_of(int'(fetch_ep), fetch_dir));
            if (eng_auto) begin
                eng_ep = fetch_ep; eng_dir = fetch_dir; eng_wait = eng_lat;
            end
        end
    end

    // ---------------- stimulus helpers (time kept at negedge+2) ----------------
    task automatic step(int n);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic consume_all();
        buf_consumed = 8'hFF; step(1); buf_consumed = '0;
    endtask

    task automatic wait_log(int n);
        for (int i = 0; i < 300 && log_q.size() < n; i++) step(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lb;
        step(3);
        rst_n = 1'b1;
        // R11 reset state
        rd(2'd0, v); chk("R11 prime after reset", v, 32'h0);
        rd(2'd1, v); chk("R11 flush after reset", v, 32'h0);
        chk("R11 primed after reset", {24'b0, primed_status}, 32'h0);
        chk("R11 fetch_req after reset", {31'b0, fetch_req}, 32'h0);

        // R2 other offsets ignore writes, read zero
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R2 offset 2 reads zero", v, 32'h0);
        rd(2'd0, v); chk("R2 offset 2 write no prime", v, 32'h0);
        // R2 reserved flush bits ignored
        wr(2'd1, 32'hFFF0_FFF0);
        rd(2'd1, v); chk("R2 reserved flush bits", v, 32'h0);

        // R1 R2 R3 prime receive ep2 with reserved bits set
        eng_lat = 3;
        wr(2'd0, 32'h0000_FFF4);
        rd(2'd0, v); chk("R1 R3 prime rx ep2 bit 2", v, 32'h0000_0004);
        step(10);
        rd(2'd0, v); chk("R4 prime bit cleared after done", v, 32'h0);
        chk("R4 primed flag rx ep2", {24'b0, primed_status}, 32'h0000_0004);

        // R10 consume clears primed
        consume_all();
        chk("R10 consume clears primed", {24'b0, primed_status}, 32'h0);

        // R3 writing 0 has no effect; R4 wrong done ignored
        eng_auto = 0;
        lb = log_q.size();
        wr(2'd0, 32'h0002_0000);
        rd(2'd0, v); chk("R1 prime tx ep1 bit 17", v, 32'h0002_0000);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R3 write zero keeps bit", v, 32'h0002_0000);
        wait_log(lb + 1);
        chk("R4 request issued tx ep1", log_q.size() > lb ? log_q[lb] : -1, 5);
        inj_ep = 2'd2; inj_dir = 1'b1; inj_seq++;
        step(2);
        rd(2'd0, v); chk("R4 wrong done keeps prime", v, 32'h0002_0000);
        chk("R4 wrong done no primed", {24'b0, primed_status}, 32'h0);
        inj_ep = 2'd1; inj_dir = 1'b1; inj_seq++;
        step(2);
        rd(2'd0, v); chk("R4 matching done clears prime", v, 32'h0);
        chk("R4 matching done sets primed", {24'b0, primed_status}, 32'h0000_0020);
        eng_auto = 1; eng_lat = 1;
        consume_all();

        // R5 service order with all eight pending
        lb = log_q.size();
        wr(2'd0, 32'h000F_000F);
        wait_log(lb + 8);
        for (int k = 0; k < 8; k++)
            chk("R5 service order", log_q.size() > lb + k ? log_q[lb + k] : -1,
                slot_of(k / 2, (k % 2) == 0));
        step(4);
        chk("R5 all slots primed", {24'b0, primed_status}, 32'h0000_00FF);
        consume_all();

        // R6 hardware re-prime of tx ep3
        eng_lat = 3;
        reprime_ep = 2'd3; reprime_dir = 1'b1; reprime_start = 1'b1;
        step(1);
        reprime_start = 1'b0;
        rd(2'd0, v); chk("R6 reprime raises bit 19", v, 32'h0008_0000);
        step(10);
        rd(2'd0, v); chk("R6 reprime bit cleared", v, 32'h0);
        chk("R6 reprime primes slot", {24'b0, primed_status}, 32'h0000_0080);
        consume_all();

        // R8 R7 flush deferred by busy packet, then completes
        eng_lat = 1;
        wr(2'd0, 32'h0000_0001);
        step(6);
        chk("R4 rx ep0 primed", {24'b0, primed_status}, 32'h0000_0001);
        pkt_busy = 8'h01;
        wr(2'd1, 32'h0000_0001);
        for (int i = 0; i < 4; i++) begin
            rd(2'd1, v); chk("R8 flush held while busy", v, 32'h0000_0001);
            chk("R8 primed held while busy", {24'b0, primed_status}, 32'h0000_0001);
            step(1);
        end
        pkt_busy = 8'h00;
        step(1);
        rd(2'd1, v); chk("R7 flush bit cleared", v, 32'h0);
        chk("R7 flush discards primed", {24'b0, primed_status}, 32'h0);

        // R9 prime waits for a pending flush on the same slot
        lb = log_q.size();
        pkt_busy = 8'h02;
        wr(2'd1, 32'h0000_0002);
        wr(2'd0, 32'h0000_0002);
        step(6);
        chk("R9 no fetch while flush pending", log_q.size(), lb);
        rd(2'd0, v); chk("R9 prime stays pending", v, 32'h0000_0002);
        pkt_busy = 8'h00;
        step(8);
        chk("R9 fetch after flush", log_q.size() > lb ? log_q[lb] : -1, 1);
        chk("R9 primed after flush", {24'b0, primed_status}, 32'h0000_0002);
        rd(2'd0, v); chk("R9 prime cleared", v, 32'h0);

        // R10 consume of one slot
        buf_consumed = 8'h02; step(1); buf_consumed = '0;
        chk("R10 single consume", {24'b0, primed_status}, 32'h0);

        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule